// File: doc/BRIEF.md
# Daisy-Chainable SPI Command Slave

This block is the serial front end of a register file. An external controller exchanges 16-bit words with it over a full-duplex SPI link, most significant bit first in both directions. While chip select is low, the block returns the status word it captured when the frame opened. At the same time it collects incoming command bits. When chip select rises, it hands the last 16 received bits to the register logic, together with a one-cycle strobe. It does this only if the frame length was legal.

The block can sit in a chain with other devices whose words are whole multiples of 8 bits. Once its own 16 status bits have gone out, its serial output repeats the input bits it received 16 bit-times earlier. A frame is legal only when the bit count is 16 followed by any number of complete 8-bit groups. Any other count discards the whole frame and leaves the command register untouched.

Chip select, serial clock and serial data are resynchronised into the system clock, which must run at least four times the serial clock rate. After chip select falls and before the first rising serial clock, the output shows a latched fault flag ORed with the serial input. A fault raised anywhere in the chain therefore reaches the controller before any data is clocked. A low enable input clears the port completely.

Top module: `spi_chain_slave`

## Requirements
- R1: Serial input bits are sampled at falling serial clock edges, first bit as the most significant; on a committed frame `cmd_word` shows the last 16 bits received and `cmd_valid` is high for the same system cycle.
- R2: At the k-th rising serial clock edge of a frame (k = 1..16), `so` shows bit 16-k of the status word sampled when chip select fell; changes on `status_word` after that point do not alter the bits sent.
- R3: From the 17th rising serial clock edge on, `so` repeats the serial input bit received 16 bit positions earlier.
- R4: A frame whose falling-edge bit count is 16 + 8n (n >= 0) commits exactly once when chip select rises.
- R5: A frame of any other length (including 0, 8, fewer than 16, or not a multiple of 8 above 16) produces no strobe and leaves `cmd_word` unchanged.
- R6: Between chip select falling and the first rising serial clock edge, `so` equals `fault_pre` OR the serial input.
- R7: `so_oe` is low while chip select is high and high while a frame is open with enable high.
- R8: While `enable` is low, `so_oe` and `cmd_word` read zero, any open frame is dropped without a strobe, and chip select activity is ignored.
- R9: `cmd_valid` is never high for two consecutive system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Port enable; low clears all port state |
| csb_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| status_word | input | 16 | Status to be returned in the next frame |
| fault_pre | input | 1 | Latched fault flag sent ahead of the first clock |
| so | output | 1 | Serial data out (valid when `so_oe` is high) |
| so_oe | output | 1 | Output drive enable for `so` |
| cmd_word | output | 16 | Last committed command word |
| cmd_valid | output | 1 | One-cycle commit strobe |

## Verification
A frame counter that drifts shows up at chip select rise as a missing strobe or an extra one. A shift register that slips by one position shows up sooner: the status bits on `so` turn wrong at the first rising edge, and the forwarded chain bits turn wrong at edge 17. A snapshot that is not taken, or is taken at the wrong time, shows up in the first status bit sent after `status_word` changes mid-frame. A stale pre-bit path shows up in the interval before the first clock edge.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
    localparam int unsigned CMD_W   = 16;
    localparam int unsigned GROUP_W = 8;

    typedef struct packed {
        logic             active;
        logic             started;
        logic             csb_prev;
        logic             sclk_prev;
        logic [CMD_W-1:0] sh;
        logic             so;
        logic             oe;
        logic [CMD_W-1:0] cmd;
        logic             cmd_v;
    } port_state_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_frame_check.sv
module spi_frame_check #(
    parameter int unsigned WORD_W  = 16,
    parameter int unsigned GROUP_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_stb,
    output logic ok
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam int unsigned GRP_W = $clog2(GROUP_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [GRP_W-1:0] grp;
    } fc_t;

    fc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (bit_stb) begin
            if (st_q.cnt != CNT_W'(WORD_W)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else if (st_q.grp == GRP_W'(GROUP_W - 1)) begin
                st_d.grp = '0;
            end else begin
                st_d.grp = st_q.grp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ok = (st_q.cnt == CNT_W'(WORD_W)) && (st_q.grp == '0);
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
    import spi_chain_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GRP_BITS    = spi_chain_pkg::GROUP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             csb_n,
    input  logic             sclk,
    input  logic             si,
    input  logic [CMD_W-1:0] status_word,
    input  logic             fault_pre,
    output logic             so,
    output logic             so_oe,
    output logic [CMD_W-1:0] cmd_word,
    output logic             cmd_valid
);
    localparam logic [2:0] SYNC_RST = 3'b100;

    logic [2:0] raw_in, sync_out;
    logic       csb_s, sclk_s, si_s;
    logic       fc_ok, fc_clear, fc_bit;
    logic       cs_fall, cs_rise, ck_rise, ck_fall;

    port_state_t st_d, st_q;

    assign raw_in = {csb_n, sclk, si};

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    assign csb_s  = sync_out[2];
    assign sclk_s = sync_out[1];
    assign si_s   = sync_out[0];

    spi_frame_check #(.WORD_W(CMD_W), .GROUP_W(GRP_BITS)) i_frame (
        .clk(clk), .rst_n(rst_n), .clear(fc_clear), .bit_stb(fc_bit), .ok(fc_ok)
    );

    always_comb begin
        cs_fall  = enable && st_q.csb_prev && !csb_s;
        cs_rise  = enable && st_q.active && !st_q.csb_prev && csb_s;
        ck_rise  = !st_q.sclk_prev && sclk_s;
        ck_fall  = st_q.sclk_prev && !sclk_s;
        fc_clear = !enable || cs_fall;
        fc_bit   = enable && st_q.active && st_q.started && ck_fall && !cs_rise;

        st_d       = st_q;
        st_d.cmd_v = 1'b0;
        if (!enable) begin
            st_d           = '0;
            st_d.csb_prev  = 1'b1;
            st_d.sclk_prev = sclk_s;
        end else begin
            st_d.csb_prev  = csb_s;
            st_d.sclk_prev = sclk_s;
            if (cs_fall) begin
                st_d.active  = 1'b1;
                st_d.started = 1'b0;
                st_d.sh      = status_word;
                st_d.oe      = 1'b1;
            end else if (st_q.active) begin
                if (cs_rise) begin
                    st_d.active  = 1'b0;
                    st_d.started = 1'b0;
                    st_d.oe      = 1'b0;
                    if (fc_ok) begin
                        st_d.cmd   = st_q.sh;
                        st_d.cmd_v = 1'b1;
                    end
                end else begin
                    if (ck_rise) begin
                        st_d.started = 1'b1;
                        st_d.so      = st_q.sh[CMD_W-1];
                    end
                    if (ck_fall && st_q.started) begin
                        st_d.sh = {st_q.sh[CMD_W-2:0], si_s};
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.csb_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign so        = (st_q.active && !st_q.started) ? (fault_pre | si_s) : st_q.so;
    assign so_oe     = st_q.oe;
    assign cmd_word  = st_q.cmd;
    assign cmd_valid = st_q.cmd_v;
endmodule

// File: rtl/spi_chain_chk.sv
module spi_chain_chk
    import spi_chain_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_word,
    input logic             so_oe,
    input logic             csb_s,
    input logic             fc_ok
);
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cmd_word == '0) && !cmd_valid && !so_oe);

    a_r7_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        csb_s |=> !so_oe);

    a_r5_commit_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(fc_ok));

    a_r1_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !cmd_valid) |-> $stable(cmd_word));
endmodule

bind spi_chain_slave spi_chain_chk i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .so_oe(so_oe), .csb_s(csb_s), .fc_ok(fc_ok)
);

// File: tb/test_spi_chain_slave.sv
module test_spi_chain_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        csb_n = 1'b1;
    logic        sclk = 1'b0;
    logic        si = 1'b0;
    logic [15:0] status_word = '0;
    logic        fault_pre = 1'b0;
    logic        so, so_oe, cmd_valid;
    logic [15:0] cmd_word;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    int doubles = 0;
    int cyc = 0;
    bit prev_v = 1'b0;
    bit done = 1'b0;
    logic [15:0] exp_cmd = '0;

    always #4 clk = ~clk;

    spi_chain_slave i_spi_chain_slave (
        .clk(clk), .rst_n(rst_n), .enable(enable), .csb_n(csb_n), .sclk(sclk),
        .si(si), .status_word(status_word), .fault_pre(fault_pre), .so(so),
        .so_oe(so_oe), .cmd_word(cmd_word), .cmd_valid(cmd_valid)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cmd_valid) strobes <= strobes + 1;
        if (cmd_valid && prev_v) doubles <= doubles + 1;
        prev_v <= cmd_valid;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit frame_legal(input int n);
        return (n >= 16) && (n % 8 == 0);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic clock_bit(input logic b);
        si = b; sclk = 1'b1; tick(5);
        sclk = 1'b0; tick(5);
    endtask

    task automatic run_frame(input int nbits, input logic [63:0] bits,
                             input logic [15:0] stat, input logic pre, input logic si_pre);
        logic [15:0] snap;
        logic exp_so;
        int v0;
        status_word = stat; fault_pre = pre; si = si_pre; sclk = 1'b0;
        tick(2);
        csb_n = 1'b0;
        tick(6);
        check(so_oe == 1'b1, "R7 oe in frame", so_oe, 1);
        check(so == (pre | si_pre), "R6 pre-bit", so, pre | si_pre);
        snap = stat;
        status_word = ~stat;
        v0 = strobes;
        for (int k = 0; k < nbits; k++) begin
            si = bits[nbits-1-k]; sclk = 1'b1; tick(5);
            exp_so = (k < 16) ? snap[15-k] : bits[nbits-1-(k-16)];
            check(so == exp_so, (k < 16) ? "R2 status bit" : "R3 chain forward", so, exp_so);
            sclk = 1'b0; tick(5);
        end
        si = 1'b0; tick(2);
        csb_n = 1'b1;
        tick(8);
        check(so_oe == 1'b0, "R7 oe idle", so_oe, 0);
        if (frame_legal(nbits)) begin
            exp_cmd = bits[15:0];
            check(strobes == v0 + 1, "R4 one commit", strobes - v0, 1);
            check(cmd_word == exp_cmd, "R1 committed word", cmd_word, exp_cmd);
        end else begin
            check(strobes == v0, "R5 no commit", strobes - v0, 0);
            check(cmd_word == exp_cmd, "R5 word kept", cmd_word, exp_cmd);
        end
    endtask

    initial begin
        int lens [11] = '{0, 8, 12, 15, 16, 20, 24, 25, 32, 40, 48};
        int v0;
        void'($urandom(32'h5A17));
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check(cmd_word == 16'h0, "R8 reset word", cmd_word, 0);
        check(cmd_valid == 1'b0, "R9 reset strobe", cmd_valid, 0);
        check(so_oe == 1'b0, "R7 reset oe", so_oe, 0);
        tick(2);
        enable = 1'b1;
        tick(4);

        run_frame(16, 64'hA5C3, 16'hB00F, 1'b1, 1'b0);
        run_frame(16, 64'h1234, 16'h8001, 1'b0, 1'b1);
        run_frame(16, 64'hFFFE, 16'h7FFF, 1'b0, 1'b0);
        run_frame(0,  64'h0,    16'h1111, 1'b0, 1'b0);
        run_frame(8,  64'hAA,   16'h2222, 1'b0, 1'b0);
        run_frame(15, 64'h5555, 16'h3333, 1'b0, 1'b0);
        run_frame(17, 64'h1ABCD, 16'h4444, 1'b0, 1'b0);
        run_frame(24, 64'hC0FFEE, 16'h5A5A, 1'b1, 1'b1);
        run_frame(23, 64'h7BEEF1, 16'h6666, 1'b0, 1'b0);
        run_frame(32, 64'hDEADBEEF, 16'h0F0F, 1'b0, 1'b0);

        for (int r = 0; r < 16; r++) begin
            logic [63:0] b;
            b = {$urandom, $urandom};
            run_frame(lens[$urandom_range(0, 10)], b, 16'($urandom), 1'($urandom), 1'($urandom));
        end

        // R8: enable dropped mid-frame
        csb_n = 1'b0; tick(6);
        for (int k = 0; k < 8; k++) clock_bit(1'b1);
        v0 = strobes;
        enable = 1'b0;
        tick(3);
        check(so_oe == 1'b0, "R8 oe off when disabled", so_oe, 0);
        check(cmd_word == 16'h0, "R8 word cleared", cmd_word, 0);
        for (int k = 0; k < 8; k++) clock_bit(1'b1);
        csb_n = 1'b1; tick(8);
        check(strobes == v0, "R8 no commit while disabled", strobes - v0, 0);
        csb_n = 1'b0; tick(6);
        for (int k = 0; k < 16; k++) clock_bit(1'b0);
        check(so_oe == 1'b0, "R8 frame ignored while disabled", so_oe, 0);
        csb_n = 1'b1; tick(8);
        check(strobes == v0, "R8 ignored frame no strobe", strobes - v0, 0);
        check(cmd_word == 16'h0, "R8 word stays clear", cmd_word, 0);
        enable = 1'b1;
        exp_cmd = 16'h0;
        tick(4);
        run_frame(16, 64'h6C3A, 16'h9009, 1'b0, 1'b0);

        check(doubles == 0, "R9 strobe width", doubles, 0);
        finish_run();
    end
endmodule